// File: doc/BRIEF.md
# Sequential Stream Prefetch Buffer

This unit sits beside a direct-mapped data cache and keeps a short queue of lines that follow the most recent miss. The cache presents every demand miss to the lookup port. If the oldest queued line has the missing address, the unit answers with a hit. It hands that line to the cache over the fill port in the same cycle and asks memory for the next line in the stream, so the queue stays ahead of a sequential walk.

If the oldest queued line does not have the missing address, the unit answers with a miss in the same cycle. The cache then fetches the line itself. The unit drops its queue and starts a new stream at the missing line plus one. The unit has one memory read port. It keeps at most one read in flight and asks for lines in ascending order. A lookup that matches a queued line whose data is still on its way is held without an answer until the data arrives.

Top module: `pfb_stream_buffer`

## Requirements
- R1: After reset no memory request is made until a lookup occurs, and the queue is empty.
- R2: A lookup whose line is not the oldest queued line is answered in the same cycle with `lk_ack`=1, `lk_hit`=0 and `fill_valid`=0.
- R3: A lookup that misses the queue at line A invalidates every queued line. The next requests are then A+1 and A+2, in that order.
- R4: The queue holds two lines, counting lines in flight. When two lines are held, no further request is made.
- R5: At most one memory request is outstanding. No request is issued between an accepted request and its response.
- R6: A lookup that matches the oldest queued line whose data is present is answered in the same cycle with `lk_hit`=1 and `lk_data` equal to that line. In that cycle `fill_valid`=1, `fill_addr` is the lookup address and `fill_data` is the line.
- R7: After a hit, the next request is for the line that follows the newest line in the queue.
- R8: Only the oldest queued line is compared. A lookup that matches only the second line is a miss and restarts the stream (R3).
- R9: A lookup that matches the oldest line while its data is still in flight gets no acknowledge until the data returns. It is then answered as a hit carrying the returned data.
- R10: A response to a request issued before a restart is discarded and never delivered as a line of the new stream.
- R11: Within a stream, requested line addresses rise by exactly one from one request to the next.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_valid | input | 1 | Demand-miss lookup present; held until acknowledged |
| lk_addr | input | 16 | Line address of the missing line |
| lk_ack | output | 1 | Lookup answered this cycle |
| lk_hit | output | 1 | Lookup found its line in the queue |
| lk_data | output | 32 | Line data for a hit |
| fill_valid | output | 1 | Line transfer into the cache this cycle |
| fill_addr | output | 16 | Line address being transferred |
| fill_data | output | 32 | Line data being transferred |
| mem_req_valid | output | 1 | Memory read request |
| mem_req_addr | output | 16 | Line address requested |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_rsp_valid | input | 1 | Memory returns the requested line |
| mem_rsp_data | input | 32 | Returned line data |

## Verification
The assertions rely on two things about the inputs. Memory returns a response only while a request of this unit is outstanding, and returns exactly one response per accepted request. The requester holds `lk_valid` and `lk_addr` steady until it sees `lk_ack`. The bench memory model keeps the first rule: it has a single slot and answers each accepted read once after a set latency. The lookup task keeps the second rule: it raises `lk_valid` at a falling edge and lowers it only after the rising edge at which the acknowledge was seen. Stalls and discards are driven by lengthening the model's latency, so a lookup or a restart falls inside the flight time of a read.

// File: rtl/pfb_pkg.sv
package pfb_pkg;
    parameter int unsigned PFB_AW    = 16;
    parameter int unsigned PFB_LW    = 32;
    parameter int unsigned PFB_DEPTH = 2;

    typedef struct packed {
        logic              v;
        logic              p;
        logic [PFB_AW-1:0] a;
        logic [PFB_LW-1:0] d;
    } pfb_ent_t;
endpackage

// File: rtl/pfb_head_check.sv
module pfb_head_check #(
    parameter int unsigned AW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          lk_valid,
    input  logic [AW-1:0] lk_addr,
    input  logic          head_v,
    input  logic          head_p,
    input  logic [AW-1:0] head_a,
    output logic          pop,
    output logic          stall,
    output logic          restart
);
    logic match;

    always_comb begin
        match   = head_v && (head_a == lk_addr);
        pop     = lk_valid && match && !head_p;
        stall   = lk_valid && match && head_p;
        restart = lk_valid && !match;
    end

    // R2 R6 R9: a lookup takes exactly one outcome
    assert_one_outcome_R2: assert property (@(posedge clk) disable iff (!rst_n)
        lk_valid |-> $countones({pop, stall, restart}) == 1);

    // R9: a stalled lookup is still matching the queue head
    assert_stall_holds_head_R9: assert property (@(posedge clk) disable iff (!rst_n)
        stall |-> head_v);
endmodule

// File: rtl/pfb_mem_issue.sv
module pfb_mem_issue #(
    parameter int unsigned AW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          restart,
    input  logic [AW-1:0] restart_addr,
    input  logic          slot_free,
    output logic          mem_req_valid,
    output logic [AW-1:0] mem_req_addr,
    input  logic          mem_req_ready,
    input  logic          mem_rsp_valid,
    output logic          alloc_fire,
    output logic          rsp_accept
);
    typedef struct packed {
        logic          active;
        logic          outst;
        logic          discard;
        logic [AW-1:0] next_addr;
    } issue_t;

    issue_t q, d;
    logic   fire;

    always_comb begin
        d             = q;
        mem_req_valid = q.active && !q.outst && slot_free;
        mem_req_addr  = q.next_addr;
        fire          = mem_req_valid && mem_req_ready;
        rsp_accept    = mem_rsp_valid && q.outst && !q.discard;
        alloc_fire    = fire && !restart;

        if (mem_rsp_valid) begin
            d.outst   = 1'b0;
            d.discard = 1'b0;
        end
        if (fire) begin
            d.outst     = 1'b1;
            d.next_addr = q.next_addr + 1'b1;
        end
        if (restart) begin
            d.active    = 1'b1;
            d.next_addr = restart_addr + 1'b1;
            d.discard   = fire || (q.outst && !mem_rsp_valid);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    // R5: input assumption, memory answers only an outstanding read
    assert_rsp_only_when_busy_R5: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rsp_valid |-> q.outst);

    // R5: an accepted request blocks the next one
    assert_single_outstanding_R5: assert property (@(posedge clk) disable iff (!rst_n)
        fire |=> !mem_req_valid);

    // R11: addresses rise by one inside a stream
    assert_ascending_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && !restart) |=> (mem_req_addr == $past(mem_req_addr) + 1'b1));

    // R1: nothing requested before the first lookup
    assert_idle_after_reset_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !q.active |-> !mem_req_valid);
endmodule

// File: rtl/pfb_stream_buffer.sv
module pfb_stream_buffer
    import pfb_pkg::*;
#(
    parameter int unsigned AW    = PFB_AW,
    parameter int unsigned LW    = PFB_LW,
    parameter int unsigned DEPTH = PFB_DEPTH
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          lk_valid,
    input  logic [AW-1:0] lk_addr,
    output logic          lk_ack,
    output logic          lk_hit,
    output logic [LW-1:0] lk_data,
    output logic          fill_valid,
    output logic [AW-1:0] fill_addr,
    output logic [LW-1:0] fill_data,
    output logic          mem_req_valid,
    output logic [AW-1:0] mem_req_addr,
    input  logic          mem_req_ready,
    input  logic          mem_rsp_valid,
    input  logic [LW-1:0] mem_rsp_data
);
    typedef struct packed {
        pfb_ent_t [DEPTH-1:0] ent;
    } buf_t;

    buf_t q, d;
    logic pop, stall, restart;
    logic alloc_fire, rsp_accept, slot_free;
    logic [DEPTH-1:0] vld_vec, pend_vec;

    pfb_head_check #(.AW(AW)) u_head (
        .clk     (clk),
        .rst_n   (rst_n),
        .lk_valid(lk_valid),
        .lk_addr (lk_addr),
        .head_v  (q.ent[0].v),
        .head_p  (q.ent[0].p),
        .head_a  (q.ent[0].a),
        .pop     (pop),
        .stall   (stall),
        .restart (restart)
    );

    pfb_mem_issue #(.AW(AW)) u_issue (
        .clk          (clk),
        .rst_n        (rst_n),
        .restart      (restart),
        .restart_addr (lk_addr),
        .slot_free    (slot_free),
        .mem_req_valid(mem_req_valid),
        .mem_req_addr (mem_req_addr),
        .mem_req_ready(mem_req_ready),
        .mem_rsp_valid(mem_rsp_valid),
        .alloc_fire   (alloc_fire),
        .rsp_accept   (rsp_accept)
    );

    genvar g;
    generate
        for (g = 0; g < DEPTH; g++) begin : g_vec
            assign vld_vec[g]  = q.ent[g].v;
            assign pend_vec[g] = q.ent[g].v && q.ent[g].p;
        end
    endgenerate

    always_comb begin
        logic placed;
        d          = q;
        placed     = 1'b0;
        slot_free  = !q.ent[DEPTH-1].v;
        lk_ack     = lk_valid && !stall;
        lk_hit     = pop;
        lk_data    = q.ent[0].d;
        fill_valid = pop;
        fill_addr  = lk_addr;
        fill_data  = q.ent[0].d;

        if (pop) begin
            for (int i = 0; i < DEPTH - 1; i++) d.ent[i] = q.ent[i+1];
            d.ent[DEPTH-1] = '0;
        end
        if (restart) d.ent = '0;
        if (rsp_accept) begin
            for (int i = 0; i < DEPTH; i++) begin
                if (d.ent[i].v && d.ent[i].p) begin
                    d.ent[i].p = 1'b0;
                    d.ent[i].d = mem_rsp_data;
                end
            end
        end
        if (alloc_fire) begin
            for (int i = 0; i < DEPTH; i++) begin
                if (!d.ent[i].v && !placed) begin
                    placed     = 1'b1;
                    d.ent[i].v = 1'b1;
                    d.ent[i].p = 1'b1;
                    d.ent[i].a = mem_req_addr;
                    d.ent[i].d = '0;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    // R5: with one read in flight at most one entry waits for data
    assert_one_pending_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(pend_vec) <= 1);

    // R3: a restart leaves the queue empty
    assert_restart_clears_R3: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> (vld_vec == '0));

    // R6: a hit removes the head, so the old second line becomes the head
    assert_hit_advances_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && q.ent[1].v) |=> (q.ent[0].a == $past(q.ent[1].a)));

    generate
        for (g = 1; g < DEPTH; g++) begin : g_chk
            // R4: entries fill from the head without gaps
            assert_packed_fifo_R4: assert property (@(posedge clk) disable iff (!rst_n)
                q.ent[g].v |-> q.ent[g-1].v);
        end
    endgenerate
endmodule

// File: tb/sim_pfb_stream_buffer.sv
`timescale 1ns/1ps
module sim_pfb_stream_buffer;
    localparam int AW = 16;
    localparam int LW = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          lk_valid = 1'b0;
    logic [AW-1:0] lk_addr = '0;
    logic          lk_ack, lk_hit, fill_valid, mem_req_valid;
    logic [LW-1:0] lk_data, fill_data;
    logic [AW-1:0] fill_addr, mem_req_addr;
    logic          mem_req_ready = 1'b1;
    logic          mem_rsp_valid;
    logic [LW-1:0] mem_rsp_data;

    int vectors = 0;
    int misses  = 0;
    int lat     = 1;
    int viol    = 0;
    int req_n   = 0;
    logic [AW-1:0] req_log [0:63];
    bit done = 0;

    always #4 clk = ~clk;

    pfb_stream_buffer u0 (
        .clk(clk), .rst_n(rst_n),
        .lk_valid(lk_valid), .lk_addr(lk_addr),
        .lk_ack(lk_ack), .lk_hit(lk_hit), .lk_data(lk_data),
        .fill_valid(fill_valid), .fill_addr(fill_addr), .fill_data(fill_data),
        .mem_req_valid(mem_req_valid), .mem_req_addr(mem_req_addr),
        .mem_req_ready(mem_req_ready),
        .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data)
    );

    function automatic logic [LW-1:0] line_of(input logic [AW-1:0] a);
        return {~a, a};
    endfunction

    // single-slot memory model
    initial begin
        bit            busy = 0;
        int            cnt  = 0;
        logic [AW-1:0] baddr = '0;
        mem_rsp_valid = 1'b0;
        mem_rsp_data  = '0;
        forever begin
            @(posedge clk);
            mem_rsp_valid <= 1'b0;
            if (busy) begin
                if (cnt <= 1) begin
                    mem_rsp_valid <= 1'b1;
                    mem_rsp_data  <= line_of(baddr);
                    busy = 0;
                end else cnt--;
            end
            if (rst_n && mem_req_valid && mem_req_ready) begin
                if (busy) viol++;
                busy  = 1;
                cnt   = lat;
                baddr = mem_req_addr;
                if (req_n < 64) req_log[req_n] = mem_req_addr;
                req_n++;
            end
        end
    end

    task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        vectors++;
        if (!ok) begin
            misses++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(posedge clk);
    endtask

    task automatic lookup(input logic [AW-1:0] a, output bit hit, output logic [LW-1:0] dat,
                          output bit fv, output logic [AW-1:0] fa, output logic [LW-1:0] fd,
                          output int waited);
        waited = 0;
        @(negedge clk);
        lk_valid = 1'b1;
        lk_addr  = a;
        #1;
        while (!lk_ack && waited < 200) begin
            @(negedge clk);
            #1;
            waited++;
        end
        hit = lk_hit; dat = lk_data; fv = fill_valid; fa = fill_addr; fd = fill_data;
        @(posedge clk);
        #1;
        lk_valid = 1'b0;
    endtask

    bit h, fv;
    logic [LW-1:0] dat, fd;
    logic [AW-1:0] fa;
    int w;

    task automatic t_reset;
        @(negedge clk);
        check(mem_req_valid == 1'b0, "R1 no request after reset", 64'(mem_req_valid), 64'd0);
        idle(5);
        check(req_n == 0, "R1 idle request count", 64'(req_n), 64'd0);
    endtask

    task automatic t_first_miss;
        lookup(16'h0100, h, dat, fv, fa, fd, w);
        check(h == 1'b0, "R2 miss reports no hit", 64'(h), 64'd0);
        check(fv == 1'b0, "R2 miss makes no fill", 64'(fv), 64'd0);
        idle(20);
        check(req_n == 2, "R4 two lines then stop", 64'(req_n), 64'd2);
        check(req_log[0] == 16'h0101, "R3 first prefetch", 64'(req_log[0]), 64'h101);
        check(req_log[1] == 16'h0102, "R3 second prefetch", 64'(req_log[1]), 64'h102);
    endtask

    task automatic t_hit;
        lookup(16'h0101, h, dat, fv, fa, fd, w);
        check(h == 1'b1, "R6 head hit", 64'(h), 64'd1);
        check(dat == line_of(16'h0101), "R6 hit data", 64'(dat), 64'(line_of(16'h0101)));
        check(fv == 1'b1 && fa == 16'h0101, "R6 fill address", 64'(fa), 64'h101);
        check(fd == line_of(16'h0101), "R6 fill data", 64'(fd), 64'(line_of(16'h0101)));
        idle(20);
        check(req_n == 3 && req_log[2] == 16'h0103, "R7 refill after hit", 64'(req_log[2]), 64'h103);
    endtask

    task automatic t_stream;
        lookup(16'h0102, h, dat, fv, fa, fd, w);
        idle(20);
        lookup(16'h0103, h, dat, fv, fa, fd, w);
        check(h == 1'b1 && dat == line_of(16'h0103), "R6 streamed hit", 64'(dat), 64'(line_of(16'h0103)));
        idle(20);
        check(req_n == 5 && req_log[3] == 16'h0104 && req_log[4] == 16'h0105,
              "R11 ascending stream", 64'(req_log[4]), 64'h105);
    endtask

    task automatic t_second_only;
        lookup(16'h0105, h, dat, fv, fa, fd, w);
        check(h == 1'b0 && fv == 1'b0, "R8 second entry is a miss", 64'(h), 64'd0);
        idle(20);
        check(req_n == 7 && req_log[5] == 16'h0106 && req_log[6] == 16'h0107,
              "R3 restart after second-entry miss", 64'(req_log[5]), 64'h106);
        lookup(16'h0106, h, dat, fv, fa, fd, w);
        check(h == 1'b1 && dat == line_of(16'h0106), "R8 new stream hit", 64'(dat), 64'(line_of(16'h0106)));
        idle(20);
    endtask

    task automatic t_stall;
        lat = 10;
        lookup(16'h0200, h, dat, fv, fa, fd, w);
        idle(2);
        lookup(16'h0201, h, dat, fv, fa, fd, w);
        check(w >= 5, "R9 lookup held while pending", 64'(w), 64'd5);
        check(h == 1'b1 && dat == line_of(16'h0201), "R9 hit after return", 64'(dat), 64'(line_of(16'h0201)));
        idle(40);
    endtask

    task automatic t_discard;
        int  k;
        bit  seen302;
        lookup(16'h0300, h, dat, fv, fa, fd, w);
        idle(3);
        lookup(16'h0400, h, dat, fv, fa, fd, w);
        idle(15);
        lookup(16'h0401, h, dat, fv, fa, fd, w);
        check(h == 1'b1 && dat == line_of(16'h0401), "R10 stale line dropped", 64'(dat), 64'(line_of(16'h0401)));
        k = -1;
        seen302 = 0;
        for (int i = 0; i < req_n && i < 64; i++) begin
            if (req_log[i] == 16'h0301) k = i;
            if (req_log[i] == 16'h0302) seen302 = 1;
        end
        check(k >= 0 && k + 1 < req_n && req_log[k+1] == 16'h0401, "R11 restart order",
              64'((k >= 0 && k + 1 < 64) ? req_log[k+1] : '0), 64'h401);
        check(!seen302, "R10 old stream stopped", 64'(seen302), 64'd0);
        check(viol == 0, "R5 single outstanding", 64'(viol), 64'd0);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        t_reset();
        t_first_miss();
        t_hit();
        t_stream();
        t_second_only();
        t_stall();
        t_discard();
        done = 1;
        $display("  == %0d vectors applied, %0d miscompares ==", vectors, misses);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            vectors++;
            misses++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("  == %0d vectors applied, %0d miscompares ==", vectors, misses);
            $finish;
        end
    end
endmodule